// File: doc/BRIEF.md
# Reference Clock Loss Supervisor

This block watches a reference clock, already synchronized into the system clock domain, and decides whether a clock generator may call itself locked. Each reference edge arrives as a one-cycle pulse together with the measured length of the period that ended at that edge, counted in system clock cycles. The supervisor keeps the last period it accepted and judges each new period against it.

When the reference stops cleanly, the lock status does not fall at once. A timeout counter gives a long grace interval of 2^TMO_W system cycles. With the default width of 23 and a system clock between about 8 MHz and 18 MHz, this is roughly 0.47 s to 1.05 s. A period that jumps outside a 1/8 band is a glitch and drops lock on the next clock. On a slow reference an optional skip mode absorbs missing pulses. After any unlock, lock only returns once the reference has produced a run of consistent periods. The output-enable either follows lock or stays on, depending on a configuration input.

Top module: `refclk_loss_supervisor`

## Requirements
- R1: While reset is asserted and right after it, `locked` is 0 and `out_en` equals `run_unlocked`.
- R2: After reset or any unlock, the first reference edge only records its period. `locked` rises on the clock that samples the RELOCK_N-th further consecutive in-band edge and is visible from the next cycle.
- R3: An edge is in band when |period − accepted| ≤ floor(accepted / 8). An in-band edge replaces the accepted period and leaves a held lock in place.
- R4: If no edge arrives, `locked` stays high for exactly 2^TMO_W cycles after the clock that sampled the last edge, then falls. Nothing else drops lock except R5 and R7.
- R5: While locked, an edge that is out of band and not absorbed by R6 drops `locked` on the next cycle. That edge's period becomes the first recorded period of a new acquisition.
- R6: Skip mode: when `skip_en` is 1 and the accepted period is at least SLOW_PER, an edge that is out of band, longer than the accepted period and not longer than SKIP_LIM keeps lock. It leaves the accepted period unchanged and restarts the timeout.
- R7: When the accepted period is below SLOW_PER, `skip_en` has no effect, so a missing pulse unlocks as in R5.
- R8: `out_en` is 1 whenever `locked` is 1 or `run_unlocked` is 1, and 0 otherwise.
- R9: A reference that returns after a timeout unlock needs a first edge plus RELOCK_N in-band edges before `locked` rises again.
- R10: During acquisition, an out-of-band edge clears the run count and becomes the new recorded period.
- R11: An edge that arrives on the very clock where the timeout reaches its terminal count wins, and lock is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse per synchronized reference edge |
| ref_period | input | PER_W | Measured period ending at this edge, in system cycles |
| skip_en | input | 1 | Enables tolerance of missing pulses on a slow reference |
| run_unlocked | input | 1 | 1: output keeps running while unlocked; 0: output held |
| locked | output | 1 | Lock status |
| out_en | output | 1 | Output clock gate enable |

## Verification
Every lock decision is registered, so a change caused by an edge sampled at a clock appears one cycle later. `out_en` follows `locked` and `run_unlocked` in the same cycle. The timeout drop appears 2^TMO_W cycles after the edge-sampling clock, and an edge placed on exactly that clock must keep lock. The bench drives inputs on the falling edge, lets one rising edge pass, and advances its own model at that rising edge. It compares `locked` and `out_en` on the following falling edge. Each registered result is therefore checked in the first cycle it is due, including the exact boundary clock of the timeout.

// File: rtl/rcls_pkg.sv
package rcls_pkg;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_OK     = 2'd1,
    EV_SKIP   = 2'd2,
    EV_GLITCH = 2'd3
  } edge_kind_e;

  // absolute distance between two periods
  function automatic logic [31:0] period_gap(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // new period lies within 1/8 of the accepted one
  function automatic logic in_band(input logic [31:0] acc, input logic [31:0] per);
    return period_gap(acc, per) <= (acc >> 3);
  endfunction

  // long period on a slow reference that skip mode may absorb
  function automatic logic skippable(input logic [31:0] acc, input logic [31:0] per,
                                     input logic [31:0] slow, input logic [31:0] lim);
    return (acc >= slow) && (per > acc) && (per <= lim);
  endfunction

endpackage

// File: rtl/rcls_timeout.sv
module rcls_timeout #(
  parameter int TMO_W = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic fire
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign fire = &cnt_q;
endmodule

// File: rtl/rcls_period_judge.sv
module rcls_period_judge
  import rcls_pkg::*;
#(
  parameter int PER_W    = 20,
  parameter int SLOW_PER = 150,
  parameter int SKIP_LIM = 240000
) (
  input  logic             ref_edge,
  input  logic [PER_W-1:0] ref_period,
  input  logic [PER_W-1:0] acc_period,
  input  logic             skip_en,
  output edge_kind_e       kind
);
  logic [31:0] acc_w, per_w;
  logic        band_ok, skip_ok;

  assign acc_w   = 32'(acc_period);
  assign per_w   = 32'(ref_period);
  assign band_ok = in_band(acc_w, per_w);
  assign skip_ok = skip_en && skippable(acc_w, per_w, 32'(SLOW_PER), 32'(SKIP_LIM));

  always_comb begin
    if (!ref_edge)    kind = EV_NONE;
    else if (band_ok) kind = EV_OK;
    else if (skip_ok) kind = EV_SKIP;
    else              kind = EV_GLITCH;
  end
endmodule

// File: rtl/refclk_loss_supervisor.sv
module refclk_loss_supervisor
  import rcls_pkg::*;
#(
  parameter int TMO_W    = 23,
  parameter int PER_W    = 20,
  parameter int RELOCK_N = 16,
  parameter int SLOW_PER = 150,
  parameter int SKIP_LIM = 240000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic [PER_W-1:0] ref_period,
  input  logic             skip_en,
  input  logic             run_unlocked,
  output logic             locked,
  output logic             out_en
);
  localparam int GW = $clog2(RELOCK_N + 1);

  logic             locked_q, have_q;
  logic [PER_W-1:0] acc_q;
  logic [GW-1:0]    good_q;
  edge_kind_e       kind;
  logic             tmo_fire;

  // named events for the checker
  logic first_edge, edge_ok, edge_skip, edge_glitch, lock_set;
  assign first_edge  = ref_edge && !have_q;
  assign edge_ok     = have_q && (kind == EV_OK);
  assign edge_skip   = have_q && (kind == EV_SKIP);
  assign edge_glitch = have_q && (kind == EV_GLITCH);
  assign lock_set    = edge_ok && !locked_q && (good_q == GW'(RELOCK_N - 1));

  rcls_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ref_edge),
    .fire (tmo_fire)
  );

  rcls_period_judge #(.PER_W(PER_W), .SLOW_PER(SLOW_PER), .SKIP_LIM(SKIP_LIM)) u_judge (
    .ref_edge  (ref_edge),
    .ref_period(ref_period),
    .acc_period(acc_q),
    .skip_en   (skip_en),
    .kind      (kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      have_q   <= 1'b0;
      acc_q    <= '0;
      good_q   <= '0;
    end else if (ref_edge) begin
      if (first_edge) begin
        have_q <= 1'b1;
        acc_q  <= ref_period;
        good_q <= '0;
      end else if (edge_ok) begin
        acc_q <= ref_period;
        if (!locked_q) good_q <= good_q + 1'b1;
        if (lock_set)  locked_q <= 1'b1;
      end else if (edge_skip && locked_q) begin
        acc_q <= acc_q;
      end else begin
        locked_q <= 1'b0;
        acc_q    <= ref_period;
        good_q   <= '0;
      end
    end else if (tmo_fire) begin
      locked_q <= 1'b0;
      have_q   <= 1'b0;
      good_q   <= '0;
    end
  end

  assign locked = locked_q;
  assign out_en = locked_q | run_unlocked;
endmodule

// File: rtl/rcls_checker.sv
module rcls_checker
  import rcls_pkg::*;
#(
  parameter int PER_W    = 20,
  parameter int SLOW_PER = 150
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_edge,
  input logic             skip_en,
  input logic             run_unlocked,
  input logic             locked,
  input logic             out_en,
  input logic [PER_W-1:0] acc_q,
  input logic             edge_ok,
  input logic             edge_skip,
  input logic             edge_glitch,
  input logic             tmo_fire
);
  AST_GLITCH_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ref_edge && edge_glitch) |=> !locked); // R5

  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ref_edge && edge_skip) |=> locked); // R6

  AST_SKIP_NEEDS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && edge_skip) |-> (skip_en && (32'(acc_q) >= 32'(SLOW_PER)))); // R7

  AST_TMO_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !ref_edge && tmo_fire) |=> !locked); // R4

  AST_NO_SPONT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !ref_edge && !tmo_fire) |=> locked); // R4

  AST_EDGE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ref_edge && edge_ok) |=> locked); // R11

  AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_edge && edge_ok)); // R2

  AST_GATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || run_unlocked) |-> out_en); // R8

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !run_unlocked) |-> !out_en); // R8
endmodule

bind refclk_loss_supervisor rcls_checker #(.PER_W(PER_W), .SLOW_PER(SLOW_PER)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_edge    (ref_edge),
  .skip_en     (skip_en),
  .run_unlocked(run_unlocked),
  .locked      (locked),
  .out_en      (out_en),
  .acc_q       (acc_q),
  .edge_ok     (edge_ok),
  .edge_skip   (edge_skip),
  .edge_glitch (edge_glitch),
  .tmo_fire    (tmo_fire)
);

// File: tb/sim_refclk_loss_supervisor.sv
module sim_refclk_loss_supervisor;
  localparam int TMO_W    = 10;
  localparam int PER_W    = 16;
  localparam int RELOCK_N = 16;
  localparam int SLOW_PER = 200;
  localparam int SKIP_LIM = 1200;
  localparam int TMO_LEN  = 1 << TMO_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_edge = 1'b0;
  logic [PER_W-1:0] ref_period = '0;
  logic skip_en = 1'b0;
  logic run_unlocked = 1'b0;
  logic locked, out_en;

  always #2.5 clk = ~clk;

  refclk_loss_supervisor #(.TMO_W(TMO_W), .PER_W(PER_W), .RELOCK_N(RELOCK_N),
                           .SLOW_PER(SLOW_PER), .SKIP_LIM(SKIP_LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .ref_period(ref_period),
    .skip_en(skip_en), .run_unlocked(run_unlocked), .locked(locked), .out_en(out_en));

  int total = 0;
  int bad = 0;
  string tag = "R1";

  // bench model
  bit m_locked = 0, m_have = 0;
  int m_acc = 0, m_good = 0, m_idle = 0;

  function automatic bit near(int acc, int p);
    int d = (p > acc) ? p - acc : acc - p;
    return d <= acc / 8;
  endfunction

  task automatic model_step(input bit e, input int p);
    if (e) begin
      m_idle = 0;
      if (!m_have) begin
        m_have = 1; m_acc = p; m_good = 0;
      end else if (near(m_acc, p)) begin
        m_acc = p;
        if (!m_locked) begin
          m_good++;
          if (m_good == RELOCK_N) m_locked = 1;
        end
      end else if (m_locked && skip_en && m_acc >= SLOW_PER && p > m_acc && p <= SKIP_LIM) begin
        // absorbed missing pulse
      end else begin
        m_locked = 0; m_acc = p; m_good = 0;
      end
    end else begin
      m_idle++;
      if (m_idle % TMO_LEN == 0) begin
        m_locked = 0; m_have = 0; m_good = 0;
      end
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // one cycle: drive at the falling edge, step at rising, compare at next falling
  task automatic tick(input bit e, input int p);
    ref_edge = e;
    ref_period = PER_W'(p);
    @(posedge clk);
    model_step(e, p);
    @(negedge clk);
    ref_edge = 1'b0;
    check(tag, locked, m_locked, "locked");
    check("R8", out_en, m_locked | run_unlocked, "out_en");
  endtask

  task automatic pulse(input int gap, input int p);
    for (int k = 1; k < gap; k++) tick(0, 0);
    tick(1, p);
  endtask

  task automatic acquire(input int p);
    for (int k = 0; k <= RELOCK_N; k++) pulse(p, p);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", locked, 1'b0, "locked in reset");
    check("R1", out_en, 1'b0, "out_en in reset");
    run_unlocked = 1'b1;
    @(negedge clk);
    check("R1", out_en, 1'b1, "out_en in reset with run_unlocked");
    run_unlocked = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", locked, 1'b0, "locked after reset");

    // R2 acquisition on a fast reference, one short of the run first
    tag = "R2";
    pulse(40, 40);
    for (int k = 1; k < RELOCK_N; k++) pulse(40, 40);
    check("R2", locked, 1'b0, "one edge short of the run");
    pulse(40, 40);
    check("R2", locked, 1'b1, "lock after full run");

    // R3 in-band jitter, including exact band edges (40/8 = 5)
    tag = "R3";
    pulse(45, 45);
    pulse(40, 40);
    pulse(35, 35);
    for (int k = 0; k < 20; k++) begin
      int p = 40 + int'($urandom % 5) - 2;
      pulse(p, p);
    end
    check("R3", locked, 1'b1, "held through jitter");

    // R5 glitch drops lock, R10 glitch during acquisition restarts count
    tag = "R5";
    pulse(40, 40);
    pulse(60, 60);
    check("R5", locked, 1'b0, "glitch unlock");
    tag = "R10";
    for (int k = 0; k < 8; k++) pulse(60, 60);
    pulse(30, 30);
    for (int k = 1; k < RELOCK_N; k++) pulse(30, 30);
    check("R10", locked, 1'b0, "count restarted");
    pulse(30, 30);
    check("R10", locked, 1'b1, "lock after restarted run");

    // R4 clean stop, exact boundary compared every cycle
    tag = "R4";
    for (int k = 1; k < TMO_LEN; k++) tick(0, 0);
    check("R4", locked, 1'b1, "last cycle of grace");
    tick(0, 0);
    check("R4", locked, 1'b0, "dropped at grace end");
    run_unlocked = 1'b1;
    tick(0, 0);
    check("R8", out_en, 1'b1, "running while unlocked");
    run_unlocked = 1'b0;
    tick(0, 0);
    check("R8", out_en, 1'b0, "held while unlocked");

    // R9 return after timeout
    tag = "R9";
    acquire(250);
    check("R9", locked, 1'b1, "relock after return");

    // R11 edge on the terminal clock wins
    tag = "R11";
    pulse(TMO_LEN, 250);
    check("R11", locked, 1'b1, "edge at terminal count");

    // R6 skip on slow reference
    tag = "R6";
    skip_en = 1'b1;
    pulse(500, 500);
    check("R6", locked, 1'b1, "missing pulse absorbed");
    pulse(250, 250);
    check("R6", locked, 1'b1, "accepted period kept");
    skip_en = 1'b0;
    pulse(500, 500);
    check("R6", locked, 1'b0, "no skip when disabled");

    // R7 skip ignored on fast reference
    tag = "R7";
    skip_en = 1'b1;
    acquire(40);
    pulse(80, 80);
    check("R7", locked, 1'b0, "fast reference not skipped");

    // random mix
    tag = "R3";
    for (int blk = 0; blk < 5; blk++) begin
      int base = ($urandom % 2) ? 200 + int'($urandom % 60) : 30 + int'($urandom % 30);
      skip_en = 1'($urandom % 2);
      run_unlocked = 1'($urandom % 2);
      acquire(base);
      for (int i = 0; i < 50; i++) begin
        int r = int'($urandom % 10);
        int p;
        if (r == 0)      begin tag = "R5"; p = base + base / 2; end
        else if (r == 1) begin tag = "R6"; p = 2 * base; end
        else begin
          int j = int'($urandom % (base / 8 + 1));
          tag = "R3";
          p = ($urandom % 2) ? base + j / 2 : base - j / 2;
        end
        pulse(p, p);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule